// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Line Controller

This block controls a small direct-mapped cache that uses write-back. It keeps a tag, a valid flag and a dirty flag for every line, along with the line's data words. A processor issues word reads and word writes on a request port. Hits are served from the cache alone. A write only changes the cached word and marks the line dirty; main memory is not written at that time.

On a miss the controller checks the line it is about to replace. A line that is clean or invalid is dropped with no memory traffic. A dirty line is first written to main memory. Its line address is built from the tag held for that line and the line's index. After that, the controller reads the missing line from memory. A write miss allocates a line: the line is refilled first, then the new word is merged in and the line is marked dirty. The processor waits for the whole miss.

A flush request visits every index in ascending order. It writes each dirty line back, clears its dirty flag and then signals completion. System software issues a flush before a DMA engine or another bus master reads memory. After the flush, lines stay valid and clean.

Top module: `wb_cache_ctrl`

## Requirements
- R1: Reset clears every valid and dirty flag. Right after reset, `cpu_ack`, `flush_done` and `mem_req` are low, and the first access to any address misses.
- R2: A read hit returns the cached word and raises `cpu_ack` in the clock cycle after the request is accepted, with no memory transfer.
- R3: A write hit changes only the addressed cached word and sets the line's dirty flag, with no memory transfer. A later read hit returns the new word.
- R4: A miss on a line that is clean or invalid makes exactly one memory read, at line address `cpu_addr >> log2(LINE_WORDS)`, and no memory write. Line word k is carried in bits `[k*DATA_W +: DATA_W]` of the line buses.
- R5: A miss on a dirty line first makes one memory write, at line address `{stored_tag, index}`, carrying the full cached contents. Only then does it make the refill read. The write-back clears the dirty flag.
- R6: A write miss refills the line from memory and merges the written word into it. The line ends up dirty, so its later replacement causes a write-back.
- R7: A flush writes back only the dirty lines, in ascending index order, with no memory reads. It then pulses `flush_done` for one cycle. After a flush, memory holds the latest value of every word.
- R8: After a flush, the lines stay valid and clean. A read to one of them hits, and replacing one of them causes no write-back.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wline` stay unchanged.
- R10: `cpu_ack` and `flush_done` are single-cycle pulses. They never occur together, and each is preceded by its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request; held until `cpu_ack` |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | One-cycle completion pulse |
| flush_req | input | 1 | Flush request; held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line refill |
| mem_addr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wline | output | DATA_W*LINE_WORDS | Line data for a write-back |
| mem_rline | input | DATA_W*LINE_WORDS | Line data for a refill, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current transfer |

## Verification
A stale stored tag, or a dirty flag that was dropped or never set, does not show at the ports right away. It appears at the next miss on that index or at the next flush. There it becomes a missing write-back, an extra write-back, or a write-back sent to the wrong rebuilt address. The reference model predicts the exact sequence of memory transfers for every access and flush. The memory responder checks the data of every write-back against the latest values. So a wrong flag is caught within one access to the affected index, and at the latest by the final flush and full memory comparison. A wrong valid flag or tag shows at once as a hit that takes more than one cycle, or as a miss with no transfer.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    parameter int unsigned DEF_ADDR_W     = 10;
    parameter int unsigned DEF_DATA_W     = 32;
    parameter int unsigned DEF_LINE_WORDS = 4;
    parameter int unsigned DEF_NUM_LINES  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_REFILL,
        ST_REPLY,
        ST_SCAN,
        ST_SCAN_END
    } wbc_state_e;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_WORD,
        UPD_FILL,
        UPD_CLEAN
    } wbc_upd_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } wbc_flags_t;

    // a line must be copied out before its slot is reused
    function automatic logic needs_evict(wbc_flags_t f);
        return f.valid & f.dirty;
    endfunction

endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store
    import wbc_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LINE_WORDS = DEF_LINE_WORDS,
    parameter int unsigned NUM_LINES  = DEF_NUM_LINES,
    parameter int unsigned TAG_W      = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NUM_LINES)-1:0]  rd_idx,
    output logic [DATA_W*LINE_WORDS-1:0]  rd_line,
    output logic [TAG_W-1:0]              rd_tag,
    output wbc_flags_t                    rd_flags,
    input  wbc_upd_e                      upd_op,
    input  logic [$clog2(NUM_LINES)-1:0]  upd_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] upd_off,
    input  logic [DATA_W-1:0]             upd_word,
    input  logic [TAG_W-1:0]              upd_tag,
    input  logic [DATA_W*LINE_WORDS-1:0]  upd_line,
    input  logic                          upd_dirty
);

    localparam int unsigned LINE_W = DATA_W * LINE_WORDS;

    logic [LINE_W-1:0] line_q  [NUM_LINES];
    logic [TAG_W-1:0]  tag_q   [NUM_LINES];
    wbc_flags_t        flags_q [NUM_LINES];

    // data and tags carry no reset; the flags decide their meaning
    always_ff @(posedge clk) begin
        case (upd_op)
            UPD_WORD: line_q[upd_idx][upd_off*DATA_W +: DATA_W] <= upd_word;
            UPD_FILL: begin
                line_q[upd_idx] <= upd_line;
                tag_q[upd_idx]  <= upd_tag;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                flags_q[i] <= '0;
            end
        end else begin
            case (upd_op)
                UPD_WORD:  flags_q[upd_idx].dirty <= 1'b1;
                UPD_FILL:  flags_q[upd_idx] <= '{valid: 1'b1, dirty: upd_dirty};
                UPD_CLEAN: flags_q[upd_idx].dirty <= 1'b0;
                default: ;
            endcase
        end
    end

    assign rd_line  = line_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_flags = flags_q[rd_idx];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LINE_WORDS = DEF_LINE_WORDS,
    parameter int unsigned NUM_LINES  = DEF_NUM_LINES,
    parameter int unsigned OFF_W      = $clog2(LINE_WORDS),
    parameter int unsigned IDX_W      = $clog2(NUM_LINES),
    parameter int unsigned TAG_W      = ADDR_W - OFF_W - IDX_W,
    parameter int unsigned LINE_W     = DATA_W * LINE_WORDS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    cpu_ack,
    input  logic                    flush_req,
    output logic                    flush_done,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [TAG_W+IDX_W-1:0]  mem_addr,
    output logic [LINE_W-1:0]       mem_wline,
    input  logic [LINE_W-1:0]       mem_rline,
    input  logic                    mem_ack,
    output logic [IDX_W-1:0]        rd_idx,
    input  logic [LINE_W-1:0]       rd_line,
    input  logic [TAG_W-1:0]        rd_tag,
    input  wbc_flags_t              rd_flags,
    output wbc_upd_e                upd_op,
    output logic [IDX_W-1:0]        upd_idx,
    output logic [OFF_W-1:0]        upd_off,
    output logic [DATA_W-1:0]       upd_word,
    output logic [TAG_W-1:0]        upd_tag,
    output logic [LINE_W-1:0]       upd_line,
    output logic                    upd_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    wbc_state_e        state_q, state_d;
    logic [IDX_W-1:0]  scan_q, scan_d;
    logic [DATA_W-1:0] rdata_q;
    logic              load_hit, load_mem;

    logic [OFF_W-1:0]  cpu_off;
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  look_idx;
    logic              hit;
    logic [LINE_W-1:0] merged;

    assign cpu_off  = cpu_addr[OFF_W-1:0];
    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign look_idx = (state_q == ST_SCAN) ? scan_q : cpu_idx;
    assign rd_idx   = look_idx;
    assign hit      = rd_flags.valid && (rd_tag == cpu_tag);

    // refill line with the pending write word laid over it
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_merge
        assign merged[w*DATA_W +: DATA_W] =
            (cpu_we && (cpu_off == OFF_W'(w))) ? cpu_wdata
                                               : mem_rline[w*DATA_W +: DATA_W];
    end

    always_comb begin
        state_d   = state_q;
        scan_d    = scan_q;
        upd_op    = UPD_NONE;
        upd_idx   = look_idx;
        upd_off   = cpu_off;
        upd_word  = cpu_wdata;
        upd_tag   = cpu_tag;
        upd_line  = merged;
        upd_dirty = cpu_we;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cpu_tag, cpu_idx};
        mem_wline = rd_line;
        load_hit  = 1'b0;
        load_mem  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (flush_req) begin
                    scan_d  = '0;
                    state_d = ST_SCAN;
                end else if (cpu_req) begin
                    if (hit) begin
                        if (cpu_we) upd_op = UPD_WORD;
                        load_hit = 1'b1;
                        state_d  = ST_REPLY;
                    end else if (needs_evict(rd_flags)) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {rd_tag, look_idx};
                if (mem_ack) begin
                    upd_op  = UPD_CLEAN;
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    upd_op   = UPD_FILL;
                    load_mem = 1'b1;
                    state_d  = ST_REPLY;
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            ST_SCAN: begin
                if (needs_evict(rd_flags)) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = {rd_tag, look_idx};
                end
                if (!needs_evict(rd_flags) || mem_ack) begin
                    if (mem_ack) upd_op = UPD_CLEAN;
                    if (scan_q == LAST_IDX) state_d = ST_SCAN_END;
                    else scan_d = scan_q + 1'b1;
                end
            end
            ST_SCAN_END: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
            if (load_hit) rdata_q <= rd_line[cpu_off*DATA_W +: DATA_W];
            else if (load_mem) rdata_q <= mem_rline[cpu_off*DATA_W +: DATA_W];
        end
    end

    assign cpu_rdata  = rdata_q;
    assign cpu_ack    = (state_q == ST_REPLY);
    assign flush_done = (state_q == ST_SCAN_END);

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned LINE_WORDS = DEF_LINE_WORDS,
    parameter int unsigned NUM_LINES  = DEF_NUM_LINES
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cpu_req,
    input  logic                                 cpu_we,
    input  logic [ADDR_W-1:0]                    cpu_addr,
    input  logic [DATA_W-1:0]                    cpu_wdata,
    output logic [DATA_W-1:0]                    cpu_rdata,
    output logic                                 cpu_ack,
    input  logic                                 flush_req,
    output logic                                 flush_done,
    output logic                                 mem_req,
    output logic                                 mem_we,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_addr,
    output logic [DATA_W*LINE_WORDS-1:0]         mem_wline,
    input  logic [DATA_W*LINE_WORDS-1:0]         mem_rline,
    input  logic                                 mem_ack
);

    localparam int unsigned OFF_W   = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W   = $clog2(NUM_LINES);
    localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned LADDR_W = ADDR_W - OFF_W;
    localparam int unsigned LINE_W  = DATA_W * LINE_WORDS;

    logic [IDX_W-1:0]  rd_idx;
    logic [LINE_W-1:0] rd_line;
    logic [TAG_W-1:0]  rd_tag;
    wbc_flags_t        rd_flags;
    wbc_upd_e          upd_op;
    logic [IDX_W-1:0]  upd_idx;
    logic [OFF_W-1:0]  upd_off;
    logic [DATA_W-1:0] upd_word;
    logic [TAG_W-1:0]  upd_tag;
    logic [LINE_W-1:0] upd_line;
    logic              upd_dirty;

    wbc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .flush_req(flush_req), .flush_done(flush_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack),
        .rd_idx(rd_idx), .rd_line(rd_line), .rd_tag(rd_tag), .rd_flags(rd_flags),
        .upd_op(upd_op), .upd_idx(upd_idx), .upd_off(upd_off),
        .upd_word(upd_word), .upd_tag(upd_tag), .upd_line(upd_line),
        .upd_dirty(upd_dirty)
    );

    wbc_line_store #(
        .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
        .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_line(rd_line), .rd_tag(rd_tag), .rd_flags(rd_flags),
        .upd_op(upd_op), .upd_idx(upd_idx), .upd_off(upd_off),
        .upd_word(upd_word), .upd_tag(upd_tag), .upd_line(upd_line),
        .upd_dirty(upd_dirty)
    );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int unsigned LADDR_W = 8,
    parameter int unsigned LINE_W  = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_req,
    input logic               cpu_ack,
    input logic               flush_req,
    input logic               flush_done,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [LADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0]  mem_wline
);

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wline)))
        else $error("R9 memory request changed before acknowledge");

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack)
        else $error("R10 cpu_ack longer than one cycle");

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done)
        else $error("R10 flush_done longer than one cycle");

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ack && flush_done))
        else $error("R10 cpu_ack and flush_done together");

    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(cpu_req))
        else $error("R2 cpu_ack without a request");

    p_done_after_req_r7: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> $past(flush_req))
        else $error("R7 flush_done without a flush request");

endmodule

bind wb_cache_ctrl wbc_checker #(.LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wline(mem_wline)
);

// File: tb/wb_cache_ctrl_tb.sv
module wb_cache_ctrl_tb;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int NL = 8;
    localparam int OB = 2;
    localparam int IB = 3;
    localparam int LAW = AW - OB;
    localparam int MEMW = 1 << AW;
    localparam int MEM_LAT = 2;
    localparam int WR_FLAG = 1 << 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic cpu_ack;
    logic flush_req = 1'b0;
    logic flush_done;
    logic mem_req, mem_we;
    logic [LAW-1:0] mem_addr;
    logic [DW*LW-1:0] mem_wline;
    logic [DW*LW-1:0] mem_rline;
    logic mem_ack;

    always #4 clk = ~clk;

    wb_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .NUM_LINES(NL)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .flush_req(flush_req), .flush_done(flush_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mem  [MEMW];
    logic [DW-1:0] arch [MEMW];
    bit m_valid [NL];
    int m_tag   [NL];
    bit m_dirty [NL];
    int log_q [$];
    bit in_cpu = 1'b0;
    bit in_fl = 1'b0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int mk(input int tag, input int idx, input int off);
        return (tag << (IB + OB)) | (idx << OB) | off;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // memory model: answers each line transfer after a fixed latency
    initial begin
        mem_ack = 1'b0;
        mem_rline = '0;
        for (int i = 0; i < MEMW; i++) begin
            mem[i]  = 32'hA500_0000 ^ (i * 32'h0001_0003);
            arch[i] = mem[i];
        end
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (MEM_LAT) @(negedge clk);
                if (mem_we) begin
                    for (int w = 0; w < LW; w++) begin
                        // R5 R7: write-back data equals the newest value of each word
                        chk(mem_wline[w*DW +: DW] == arch[int'(mem_addr)*LW + w], "R5/R7 wb data",
                            mem_wline[w*DW +: DW], arch[int'(mem_addr)*LW + w]);
                        mem[int'(mem_addr)*LW + w] = mem_wline[w*DW +: DW];
                    end
                    log_q.push_back(WR_FLAG | int'(mem_addr));
                end else begin
                    for (int w = 0; w < LW; w++) mem_rline[w*DW +: DW] = mem[int'(mem_addr)*LW + w];
                    log_q.push_back(int'(mem_addr));
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // per-clock comparison of the handshake outputs with the bench's own phase
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_ack && !in_cpu) chk(1'b0, "R10 stray cpu_ack", 1, 0);
            if (flush_done && !in_fl) chk(1'b0, "R10 stray flush_done", 1, 0);
            if (mem_req && !in_cpu && !in_fl) chk(1'b0, "R3 stray mem_req", 1, 0);
        end
    end

    task automatic cpu_op(input bit we, input int addr, input logic [DW-1:0] d, input string rq);
        int idx, tag, cyc, ev_la, la;
        bit hit, ev;
        int exp_q [$];
        idx = (addr >> OB) % NL;
        tag = addr >> (OB + IB);
        la  = addr >> OB;
        hit = m_valid[idx] && (m_tag[idx] == tag);
        ev  = !hit && m_valid[idx] && m_dirty[idx];
        ev_la = (m_tag[idx] << IB) | idx;
        if (ev) exp_q.push_back(WR_FLAG | ev_la);
        if (!hit) exp_q.push_back(la);
        @(negedge clk);
        log_q.delete();
        in_cpu = 1'b1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ack && cyc < 2000);
        cpu_req = 1'b0;
        chk(cyc < 2000, {rq, " ack timeout"}, cyc, 0);
        if (!we) chk(cpu_rdata == arch[addr], {rq, " read data"}, cpu_rdata, arch[addr]);
        if (hit) chk(cyc == 1, {rq, " R2 hit latency"}, cyc, 1);
        chk(log_q.size() == exp_q.size(), {rq, " transfer count"}, log_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < log_q.size(); k++)
            chk(log_q[k] == exp_q[k], {rq, " transfer order/address"}, log_q[k], exp_q[k]);
        if (we) arch[addr] = d;
        if (!hit) m_dirty[idx] = we;
        else m_dirty[idx] = m_dirty[idx] | we;
        m_valid[idx] = 1'b1;
        m_tag[idx] = tag;
        @(negedge clk);
        in_cpu = 1'b0;
    endtask

    task automatic do_flush(input string rq);
        int exp_q [$];
        int cyc;
        for (int i = 0; i < NL; i++)
            if (m_valid[i] && m_dirty[i]) exp_q.push_back(WR_FLAG | ((m_tag[i] << IB) | i));
        @(negedge clk);
        log_q.delete();
        in_fl = 1'b1;
        flush_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!flush_done && cyc < 2000);
        flush_req = 1'b0;
        chk(cyc < 2000, {rq, " flush timeout"}, cyc, 0);
        chk(log_q.size() == exp_q.size(), {rq, " flush write count"}, log_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < log_q.size(); k++)
            chk(log_q[k] == exp_q[k], {rq, " flush ascending order"}, log_q[k], exp_q[k]);
        for (int i = 0; i < NL; i++) m_dirty[i] = 1'b0;
        @(negedge clk);
        in_fl = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int bad;
        int seed;
        for (int i = 0; i < NL; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = 0; m_dirty[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs idle after reset
        chk(cpu_ack == 1'b0, "R1 cpu_ack after reset", cpu_ack, 0);
        chk(flush_done == 1'b0, "R1 flush_done after reset", flush_done, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);

        cpu_op(0, mk(1, 0, 0), '0, "R1 R4 first read misses");
        cpu_op(0, mk(1, 0, 3), '0, "R2 read hit");
        cpu_op(1, mk(1, 0, 2), 32'hDEAD_0001, "R3 write hit");
        cpu_op(0, mk(1, 0, 2), '0, "R3 read back");
        cpu_op(0, mk(2, 0, 1), '0, "R5 dirty victim");
        cpu_op(0, mk(3, 0, 0), '0, "R4 clean victim");
        cpu_op(1, mk(4, 1, 1), 32'hBEEF_0002, "R6 write miss");
        cpu_op(0, mk(4, 1, 1), '0, "R6 merged word");
        cpu_op(0, mk(4, 1, 3), '0, "R6 refilled word");
        cpu_op(0, mk(5, 1, 0), '0, "R6 dirty after write miss");
        cpu_op(1, mk(6, 2, 0), 32'h1111_2222, "R6 write miss idx2");
        cpu_op(1, mk(6, 5, 3), 32'h3333_4444, "R6 write miss idx5");
        cpu_op(1, mk(7, 7, 1), 32'h5555_6666, "R6 write miss idx7");
        cpu_op(1, mk(6, 2, 1), 32'h7777_8888, "R3 write hit idx2");
        do_flush("R7 flush dirty lines");
        cpu_op(0, mk(6, 2, 1), '0, "R8 hit after flush");
        cpu_op(0, mk(8, 5, 0), '0, "R8 clean replace after flush");
        do_flush("R7 flush with nothing dirty");

        seed = 32'h1234_5678;
        for (int n = 0; n < 120; n++) begin
            seed = seed * 1103515245 + 12345;
            cpu_op(((seed >> 8) & 1) == 1, mk((seed >> 12) & 3, (seed >> 16) & 7, (seed >> 20) & 3),
                   DW'(seed ^ n), "R2 R3 R4 R5 R6 mixed");
            if (n % 40 == 39) do_flush("R7 periodic flush");
        end
        do_flush("R7 final flush");
        bad = 0;
        for (int i = 0; i < MEMW; i++) if (mem[i] !== arch[i]) bad++;
        chk(bad == 0, "R7 memory coherent after flush", bad, 0);
        finish_run();
    end

endmodule